// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits behind a 512 KB configuration window in the processor's address map. Each access that lands in the window is turned into a type-0 PCI configuration address. The low 16 bits of the window offset are joined under a 16-bit upper field that software keeps in a mapping register, which gives a 32-bit intermediate address. The device-select lines held in the upper part of that address are one-hot in normal use. A lowest-bit-first priority encoder turns them into a slot number. That number is packed with the bus, function and register fields into a configuration address word whose enable bit is set. Only bits [15:0] of the window offset reach the block, because the remaining offset bits take no part in the translation.

Each accepted access is answered one clock later by exactly one of three outcomes. A valid access is forwarded, together with a pulse that clears both received-abort status bits. An access is also refused when translation is switched off, and a read refused for any reason gets an all-ones reply sized to the access width. An access that cannot be translated raises a one-cycle error pulse. The PCI bus cycle itself, the configuration storage of the devices and type-1 cycles are handled elsewhere.

Top module: `pcicfg_xlate`

## Requirements
- R1: After reset, and with no request, cfgValid, respValid, errPulse and statusClr are all 0.
- R2: An accepted request (reqValid high at a rising edge) that is enabled, aligned and has a nonzero select field makes cfgValid high for exactly the next cycle. In that cycle cfgWrite, cfgSize and cfgWdata equal the request's values.
- R3: The forwarded cfgAddr is built from the intermediate address I = {mapCfg[15:0], reqAddr[15:0]}. Bit 31 is 1 and bits [30:24] are 0. Bits [23:16] hold busNum and bits [15:11] hold the device number. Bits [10:8] hold I[10:8], bits [7:2] hold I[7:2], and bits [1:0] are 0.
- R4: The device number is the index, counted from I[11], of the lowest set bit in the select field I[31:11]. When several bits are set, the lowest one wins, and I[31] alone gives 20.
- R5: When mapCfg[16] is 1, translation is disabled and nothing is forwarded. A read gets respValid one cycle later with respData = 0x000000FF for reqSize 0 (byte), 0x0000FFFF for 1 (halfword) and 0xFFFFFFFF for 2 (word). A write gives no output at all.
- R6: With translation enabled, a zero select field I[31:11] raises errPulse for one cycle, and the access is not forwarded. A read then gets the all-ones reply of R5.
- R7: Two kinds of access are misaligned: a halfword (reqSize 1) with reqAddr[0] = 1, and a word (reqSize 2) with reqAddr[1:0] != 0. Size code 3 is illegal. A misaligned or illegal access raises errPulse and is not forwarded. A read then gets the all-ones reply, which is 0xFFFFFFFF for size code 3.
- R8: statusClr is 2'b11 (bit 0 clears received-master-abort, bit 1 clears received-target-abort) in exactly the cycles where cfgValid is high, and 2'b00 otherwise.
- R9: Disable takes precedence over the error checks. A disabled access never raises errPulse, even if its select field is zero or it is misaligned.
- R10: Requests on consecutive cycles each produce their own result in consecutive cycles, with no lost or merged access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mapCfg | input | 17 | Mapping register: [15:0] upper address field, [16] translation disable |
| busNum | input | 8 | Bus number placed in the output address |
| reqValid | input | 1 | Access request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| reqAddr | input | 16 | Low 16 bits of the window offset |
| reqWdata | input | 32 | Write data |
| cfgValid | output | 1 | Forwarded configuration access strobe |
| cfgWrite | output | 1 | Direction of forwarded access |
| cfgSize | output | 2 | Size of forwarded access |
| cfgAddr | output | 32 | Translated configuration address |
| cfgWdata | output | 32 | Write data of forwarded access |
| respValid | output | 1 | Local all-ones reply for a refused read |
| respData | output | 32 | All-ones reply data at access width |
| errPulse | output | 1 | One-cycle translation error |
| statusClr | output | 2 | Clear pulses for received-abort status bits |

## Verification
The hardest case to reach from the ports is the priority encoder with several select bits set at once, split across the two halves of the intermediate address. Some of those bits come from mapCfg and some from reqAddr[15:11], so the lowest-bit rule can only be observed when both sources are driven together. The bench sets a high bit in mapCfg together with a low bit in reqAddr, and separately sets only I[31]. This covers both ends of the encoder. The order of precedence between disable, zero select and misalignment is reached by stacking those faults onto one request and checking that only the disable outcome is visible.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int LO_W      = 16;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int BUS_W     = 8;
  localparam int SEL_LSB   = 11;
  localparam int SEL_W     = ADDR_W - SEL_LSB;
  localparam int DEV_W     = $clog2(SEL_W);
  localparam int MAP_W     = LO_W + 1;
  localparam int DIS_BIT   = LO_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic loadCmd;
    logic loadResp;
  } pcx_strobe_t;
endpackage

// File: rtl/pcx_lowbit.sv
module pcx_lowbit #(
  parameter int W = 21,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             none
);
  // Scan from the top down so the lowest set bit is the last one written.
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign none = ~|vec;
endmodule

// File: rtl/pcx_ctrl.sv
module pcx_ctrl
  import pcx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        mapDisable,
  input  logic        selNone,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  reqSize,
  input  logic [1:0]  addrLow,
  output pcx_strobe_t strobe,
  output logic        fwdQ,
  output logic        respQ,
  output logic        errQ,
  output logic [1:0]  clrQ
);
  logic misalign;
  logic doFwd, doResp, doErr;

  always_comb begin
    unique case (acc_size_e'(reqSize))
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = addrLow[0];
      SZ_WORD: misalign = |addrLow;
      default: misalign = 1'b1;
    endcase
  end

  // Disable is checked first; only an enabled access can be in error.
  always_comb begin
    doFwd  = 1'b0;
    doResp = 1'b0;
    doErr  = 1'b0;
    if (reqValid) begin
      if (mapDisable) begin
        doResp = !reqWrite;
      end else if (selNone || misalign) begin
        doErr  = 1'b1;
        doResp = !reqWrite;
      end else begin
        doFwd  = 1'b1;
      end
    end
  end

  assign strobe.loadCmd  = doFwd;
  assign strobe.loadResp = doResp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdQ  <= 1'b0;
      respQ <= 1'b0;
      errQ  <= 1'b0;
      clrQ  <= 2'b00;
    end else begin
      fwdQ  <= doFwd;
      respQ <= doResp;
      errQ  <= doErr;
      clrQ  <= {doFwd, doFwd};
    end
  end

  a_r6_err_blocks_fwd: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> !fwdQ);
  a_r5_fwd_resp_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(fwdQ && respQ));
  a_r9_disabled_no_err: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mapDisable) |=> !errQ);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !(fwdQ || respQ || errQ));
  a_r8_clr_with_fwd: assert property (@(posedge clk) disable iff (!rstN)
    fwdQ |-> (clrQ == 2'b11));
endmodule

// File: rtl/pcx_datapath.sv
module pcx_datapath
  import pcx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pcx_strobe_t       strobe,
  input  logic [LO_W-1:0]   mapUpper,
  input  logic [BUS_W-1:0]  busNum,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [LO_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              selNone,
  output logic [ADDR_W-1:0] cfgAddr,
  output logic              cfgWrite,
  output logic [1:0]        cfgSize,
  output logic [DATA_W-1:0] cfgWdata,
  output logic [DATA_W-1:0] respData
);
  logic [ADDR_W-1:0] interAddr;
  logic [DEV_W-1:0]  devIdx;
  logic [ADDR_W-1:0] addrNext;
  logic [DATA_W-1:0] onesNext;

  assign interAddr = {mapUpper, reqAddr};

  pcx_lowbit #(.W(SEL_W)) uSel (
    .vec  (interAddr[ADDR_W-1:SEL_LSB]),
    .idx  (devIdx),
    .none (selNone)
  );

  assign addrNext = {1'b1, 7'b0, busNum, devIdx, interAddr[10:8],
                     interAddr[7:2], 2'b00};

  always_comb begin
    unique case (acc_size_e'(reqSize))
      SZ_BYTE: onesNext = DATA_W'(8'hFF);
      SZ_HALF: onesNext = DATA_W'(16'hFFFF);
      default: onesNext = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgAddr  <= '0;
      cfgWrite <= 1'b0;
      cfgSize  <= 2'b00;
      cfgWdata <= '0;
      respData <= '0;
    end else begin
      if (strobe.loadCmd) begin
        cfgAddr  <= addrNext;
        cfgWrite <= reqWrite;
        cfgSize  <= reqSize;
        cfgWdata <= reqWdata;
      end
      if (strobe.loadResp) respData <= onesNext;
    end
  end

  a_r3_enable_and_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCmd |=> (cfgAddr[31] && cfgAddr[1:0] == 2'b00));
  a_r4_dev_in_range: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCmd |=> (int'(cfgAddr[15:11]) < SEL_W));
  a_r5_byte_ones: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadResp && reqSize == 2'd0) |=> (respData == 32'h0000_00FF));
endmodule

// File: rtl/pcicfg_xlate.sv
module pcicfg_xlate
  import pcx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [16:0] mapCfg,
  input  logic [7:0]  busNum,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  reqSize,
  input  logic [15:0] reqAddr,
  input  logic [31:0] reqWdata,
  output logic        cfgValid,
  output logic        cfgWrite,
  output logic [1:0]  cfgSize,
  output logic [31:0] cfgAddr,
  output logic [31:0] cfgWdata,
  output logic        respValid,
  output logic [31:0] respData,
  output logic        errPulse,
  output logic [1:0]  statusClr
);
  pcx_strobe_t strobe;
  logic        selNone;

  pcx_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .mapDisable (mapCfg[DIS_BIT]),
    .selNone    (selNone),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqSize    (reqSize),
    .addrLow    (reqAddr[1:0]),
    .strobe     (strobe),
    .fwdQ       (cfgValid),
    .respQ      (respValid),
    .errQ       (errPulse),
    .clrQ       (statusClr)
  );

  pcx_datapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .mapUpper (mapCfg[LO_W-1:0]),
    .busNum   (busNum),
    .reqWrite (reqWrite),
    .reqSize  (reqSize),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .selNone  (selNone),
    .cfgAddr  (cfgAddr),
    .cfgWrite (cfgWrite),
    .cfgSize  (cfgSize),
    .cfgWdata (cfgWdata),
    .respData (respData)
  );

  a_r2_fwd_has_bus: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !mapCfg[16] && !selNone && reqSize == 2'd0) |=> (cfgValid && cfgAddr[23:16] == $past(busNum)));
  a_r7_illegal_size_err: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !mapCfg[16] && reqSize == 2'd3) |=> (errPulse && !cfgValid));
endmodule

// File: tb/tb_pcicfg_xlate.sv
module tb_pcicfg_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [16:0] mapCfg = '0;
  logic [7:0]  busNum = 8'h00;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [15:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        cfgValid, cfgWrite, respValid, errPulse;
  logic [1:0]  cfgSize, statusClr;
  logic [31:0] cfgAddr, cfgWdata, respData;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pcicfg_xlate dut (
    .clk(clk), .rstN(rstN), .mapCfg(mapCfg), .busNum(busNum),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSize(reqSize),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cfgValid(cfgValid), .cfgWrite(cfgWrite), .cfgSize(cfgSize),
    .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .respValid(respValid),
    .respData(respData), .errPulse(errPulse), .statusClr(statusClr)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] refAddr(logic [16:0] m, logic [15:0] a, logic [7:0] b);
    logic [31:0] inter = {m[15:0], a};
    logic [4:0] dev = '0;
    bit found = 1'b0;
    for (int i = 11; i < 32; i++) begin
      if (!found && inter[i]) begin
        dev = 5'(i - 11);
        found = 1'b1;
      end
    end
    return {1'b1, 7'b0, b, dev, inter[10:8], inter[7:2], 2'b00};
  endfunction

  task automatic drive(logic w, logic [1:0] s, logic [15:0] a, logic [31:0] d);
    reqValid = 1'b1; reqWrite = w; reqSize = s; reqAddr = a; reqWdata = d;
  endtask

  task automatic issue(logic w, logic [1:0] s, logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    drive(w, s, a, d);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic checkQuiet(string tag);
    chk(tag, "cfgValid", 32'(cfgValid), 32'd0);
    chk(tag, "respValid", 32'(respValid), 32'd0);
    chk(tag, "errPulse", 32'(errPulse), 32'd0);
    chk(tag, "statusClr", 32'(statusClr), 32'd0);
  endtask

  task automatic checkFwd(string tag, logic w, logic [1:0] s, logic [15:0] a, logic [31:0] d);
    chk(tag, "cfgValid", 32'(cfgValid), 32'd1);
    chk(tag, "respValid", 32'(respValid), 32'd0);
    chk(tag, "errPulse", 32'(errPulse), 32'd0);
    chk("R8", "statusClr", 32'(statusClr), 32'd3);
    chk(tag, "cfgAddr", cfgAddr, refAddr(mapCfg, a, busNum));
    chk("R2", "cfgWrite", 32'(cfgWrite), 32'(w));
    chk("R2", "cfgSize", 32'(cfgSize), 32'(s));
    chk("R2", "cfgWdata", cfgWdata, d);
  endtask

  task automatic expectFwd(string tag, logic w, logic [1:0] s, logic [15:0] a, logic [31:0] d);
    issue(w, s, a, d);
    checkFwd(tag, w, s, a, d);
    @(negedge clk);
    checkQuiet("R2");
  endtask

  task automatic expectRefuse(string tag, logic w, logic [1:0] s, logic [15:0] a,
                              logic expErr, logic [31:0] ones);
    issue(w, s, a, 32'hDEAD_BEEF);
    chk(tag, "cfgValid", 32'(cfgValid), 32'd0);
    chk(tag, "errPulse", 32'(errPulse), 32'(expErr));
    chk(tag, "respValid", 32'(respValid), 32'(!w));
    chk("R8", "statusClr", 32'(statusClr), 32'd0);
    if (!w) chk(tag, "respData", respData, ones);
    @(negedge clk);
    checkQuiet(tag);
  endtask

  task automatic tReset();
    repeat (3) @(negedge clk);
    checkQuiet("R1");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkQuiet("R1");
  endtask

  task automatic tBasic();
    busNum = 8'h05;
    mapCfg = 17'h0_0002;
    expectFwd("R3", 1'b0, 2'd2, 16'h0A34, 32'h0);
    busNum = 8'hC3;
    expectFwd("R3", 1'b1, 2'd1, 16'h07FE, 32'h1234_5678);
  endtask

  task automatic tLowestWins();
    mapCfg = 17'h0_8010;
    expectFwd("R4", 1'b0, 2'd2, 16'h8800, 32'h0);
    mapCfg = 17'h0_8010;
    expectFwd("R4", 1'b0, 2'd2, 16'h0000, 32'h0);
    mapCfg = 17'h0_8000;
    expectFwd("R4", 1'b0, 2'd0, 16'h0000, 32'h0);
    chk("R4", "dev of top bit", refAddr(17'h0_8000, 16'h0, 8'h0) >> 11 & 32'h1F, 32'd20);
  endtask

  task automatic tByteWrite();
    mapCfg = 17'h0_0100;
    expectFwd("R2", 1'b1, 2'd0, 16'h0307, 32'h0000_00A5);
  endtask

  task automatic tMisaligned();
    mapCfg = 17'h0_0040;
    expectRefuse("R7", 1'b0, 2'd1, 16'h0011, 1'b1, 32'h0000_FFFF);
    expectRefuse("R7", 1'b1, 2'd2, 16'h0012, 1'b1, 32'h0);
    expectRefuse("R7", 1'b0, 2'd2, 16'h0001, 1'b1, 32'hFFFF_FFFF);
    expectRefuse("R7", 1'b0, 2'd3, 16'h0000, 1'b1, 32'hFFFF_FFFF);
  endtask

  task automatic tDisabled();
    mapCfg = 17'h1_0040;
    expectRefuse("R5", 1'b0, 2'd0, 16'h0010, 1'b0, 32'h0000_00FF);
    expectRefuse("R5", 1'b0, 2'd1, 16'h0010, 1'b0, 32'h0000_FFFF);
    expectRefuse("R5", 1'b0, 2'd2, 16'h0010, 1'b0, 32'hFFFF_FFFF);
    expectRefuse("R5", 1'b1, 2'd2, 16'h0010, 1'b0, 32'h0);
    mapCfg = 17'h1_0000;
    expectRefuse("R9", 1'b0, 2'd1, 16'h0001, 1'b0, 32'h0000_FFFF);
  endtask

  task automatic tZeroSel();
    mapCfg = 17'h0_0000;
    expectRefuse("R6", 1'b0, 2'd2, 16'h0704, 1'b1, 32'hFFFF_FFFF);
    expectRefuse("R6", 1'b1, 2'd0, 16'h0001, 1'b1, 32'h0);
  endtask

  task automatic tBackToBack();
    mapCfg = 17'h0_0004;
    busNum = 8'h11;
    @(negedge clk);
    drive(1'b0, 2'd2, 16'h0104, 32'h0);
    @(negedge clk);
    drive(1'b1, 2'd2, 16'h0808, 32'hCAFE_F00D);
    checkFwd("R10", 1'b0, 2'd2, 16'h0104, 32'h0);
    @(negedge clk);
    reqValid = 1'b0;
    checkFwd("R10", 1'b1, 2'd2, 16'h0808, 32'hCAFE_F00D);
    @(negedge clk);
    checkQuiet("R10");
  endtask

  initial begin
    tReset();
    tBasic();
    tLowestWins();
    tByteWrite();
    tMisaligned();
    tDisabled();
    tZeroSel();
    tBackToBack();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule